// File: doc/BRIEF.md
# Paravirtual Device Register Window Decoder

This block sits behind one 512 KiB memory region of a paravirtualised I/O function and splits every host access into the window it lands in. A dword-wide register bus presents a byte offset, four byte-enables and write data. The block works out which window the offset belongs to and forwards the access, with the offset made relative to that window's start, to one of four sub-ports. The sub-ports serve the shared queue-setup registers, the device-specific registers, the message-interrupt vector table and that table's pending-bit array. Read data comes back on the host side one cycle after the request.

Two windows are handled inside the block. The first is a one-byte interrupt cause register. Device logic raises causes into it. The driver reads it to fetch and clear all causes at once, or writes it to clear chosen bits. The second is the queue doorbell window. A write there is turned into a one-cycle pulse that carries the queue number, taken from the dword position inside the window. Offsets that fall in the gaps between windows, or past the end of the region, do nothing.

Top module: `vdev_bar_decoder`

## Requirements
- R1: After reset, hostRvalid and notifyValid are low and the interrupt cause byte reads as 0.
- R2: A read request (hostValid high, hostWrite low) produces hostRvalid high with hostRdata in the next cycle, one response per request, back to back. A write produces no hostRvalid.
- R3: Offsets 0x00 to 0x37 select the queue-setup sub-port (cmnSel). Offset 0x38 and above in that area is a gap.
- R4: Offsets 0x4000 to 0x4FFF select devSel, 0x8000 to 0x47FFF select tblSel and 0x48000 to 0x487FF select pbaSel. subOffset is the access offset minus the window start. The sub-port read data is returned unchanged.
- R5: A read of the dword at 0x2000 with byte-enable bit 0 set returns the cause byte in bits 7:0, zeros in bits 31:8, and clears the byte. With byte-enable bit 0 clear, the read returns 0 and clears nothing.
- R6: A write to the dword at 0x2000 with byte-enable bit 0 set clears each cause bit whose hostWdata[7:0] bit is 1 and leaves the others.
- R7: raiseUsed sets cause bit 0 and raiseCfg sets cause bit 1, ORed into the byte. A raise in the same cycle as a clear by read or write is kept.
- R8: A write at 0x6000 + 4*i pulses notifyValid for one cycle, in the cycle after the request, with notifyQueue = i (i from 0 to 1023). A read in that window returns 0 and gives no pulse.
- R9: A write to a gap (0x38-0x1FFF, 0x2004-0x3FFF, 0x5000-0x5FFF, 0x7000-0x7FFF, 0x48800-0x7FFFF) or to an offset of 0x80000 or more selects no sub-port and changes nothing. A read there returns 0.
- R10: At most one of cmnSel, devSel, tblSel and pbaSel is high in a cycle, and only while hostValid is high. The low two offset bits are ignored when decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Access request this cycle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 20 | Byte offset into the region |
| hostByteEn | input | 4 | Byte lane enables |
| hostWdata | input | 32 | Write data |
| hostRvalid | output | 1 | Read response valid |
| hostRdata | output | 32 | Read response data |
| raiseUsed | input | 1 | Raise used-ring cause (bit 0) |
| raiseCfg | input | 1 | Raise configuration-change cause (bit 1) |
| subWrite | output | 1 | Forwarded access is a write |
| subOffset | output | 18 | Offset relative to the selected window |
| subByteEn | output | 4 | Forwarded byte enables |
| subWdata | output | 32 | Forwarded write data |
| cmnSel | output | 1 | Queue-setup sub-port select |
| cmnRdata | input | 32 | Queue-setup sub-port read data |
| devSel | output | 1 | Device-register sub-port select |
| devRdata | input | 32 | Device-register sub-port read data |
| tblSel | output | 1 | Vector-table sub-port select |
| tblRdata | input | 32 | Vector-table sub-port read data |
| pbaSel | output | 1 | Pending-array sub-port select |
| pbaRdata | input | 32 | Pending-array sub-port read data |
| notifyValid | output | 1 | Doorbell pulse |
| notifyQueue | output | 10 | Queue number of the doorbell |

## Verification
Some properties are checked on every cycle. No more than one sub-port is selected at a time, and nothing is selected past the region end. Every response and every doorbell pulse traces back to a matching request in the cycle before. A raise is always visible in the cause byte one cycle later, and a read-clear with no raise leaves it at zero. Other behaviour shows only in the bench's scenarios, where a behavioural model of the region is compared against the outputs on every clock. These cover routing with the right relative offset at the first and last dword of each window, nothing left behind by gap writes, partial byte-enables, doorbell numbering at both ends of its window, and the order of clears and raises in the cause byte.

// File: rtl/vdev_bar_pkg.sv
package vdev_bar_pkg;

  localparam int unsigned REGION_BYTES = 32'h80000;
  localparam int unsigned WIN_N        = 6;
  localparam int unsigned DOORBELL_STRIDE = 4;
  localparam int unsigned CAUSE_USED_BIT  = 0;
  localparam int unsigned CAUSE_CFG_BIT   = 1;

  typedef enum logic [2:0] {
    WIN_NONE = 3'd0,
    WIN_CMN  = 3'd1,
    WIN_CAUSE = 3'd2,
    WIN_DEV  = 3'd3,
    WIN_BELL = 3'd4,
    WIN_TBL  = 3'd5,
    WIN_PBA  = 3'd6
  } winT;

  // window order here is winT minus one
  function automatic logic [31:0] winBase(input int idx);
    case (idx)
      0: winBase = 32'h0_0000;
      1: winBase = 32'h0_2000;
      2: winBase = 32'h0_4000;
      3: winBase = 32'h0_6000;
      4: winBase = 32'h0_8000;
      default: winBase = 32'h4_8000;
    endcase
  endfunction

  function automatic logic [31:0] winBytes(input int idx);
    case (idx)
      0: winBytes = 32'd56;
      1: winBytes = 32'd4;
      2: winBytes = 32'h1000;
      3: winBytes = 32'h1000;
      4: winBytes = 32'h4_0000;
      default: winBytes = 32'h800;
    endcase
  endfunction

  typedef struct packed {
    logic rdStrobe;
    logic causeRd;
    logic causeWr;
    logic bellWr;
    winT  rdSrc;
  } strbT;

endpackage

// File: rtl/vdev_bar_ctrl.sv
module vdev_bar_ctrl
  import vdev_bar_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SUB_OFF_W = 18,
  parameter int QIDX_W    = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostValid,
  input  logic                 hostWrite,
  input  logic [ADDR_W-1:0]    hostAddr,
  output strbT                 strb,
  output logic                 subWrite,
  output logic [SUB_OFF_W-1:0] subOffset,
  output logic                 cmnSel,
  output logic                 devSel,
  output logic                 tblSel,
  output logic                 pbaSel,
  output logic [QIDX_W-1:0]    bellIdx
);

  localparam int PAD_W = 32 - ADDR_W;

  logic [31:0]          addrExt;
  logic                 inRegion;
  logic [WIN_N-1:0]     winHit;
  logic [SUB_OFF_W-1:0] winOff [WIN_N];
  winT                  winSel;
  logic [SUB_OFF_W-1:0] offSel;

  assign addrExt  = {{PAD_W{1'b0}}, hostAddr};
  assign inRegion = addrExt < REGION_BYTES;

  for (genvar w = 0; w < WIN_N; w++) begin : gWin
    localparam logic [31:0] BASE  = winBase(w);
    localparam logic [31:0] BYTES = winBytes(w);
    logic [31:0] rel;
    assign rel       = addrExt - BASE;
    assign winHit[w] = inRegion && (rel < BYTES);
    assign winOff[w] = rel[SUB_OFF_W-1:0];
  end

  always_comb begin
    winSel = WIN_NONE;
    offSel = '0;
    for (int w = 0; w < WIN_N; w++) begin
      if (winHit[w]) begin
        winSel = winT'(w + 1);
        offSel = winOff[w];
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.rdSrc    = WIN_NONE;
    if (hostValid) begin
      strb.rdStrobe = !hostWrite;
      strb.causeRd  = !hostWrite && (winSel == WIN_CAUSE);
      strb.causeWr  = hostWrite && (winSel == WIN_CAUSE);
      strb.bellWr   = hostWrite && (winSel == WIN_BELL);
      strb.rdSrc    = hostWrite ? WIN_NONE : winSel;
    end
  end

  assign cmnSel    = hostValid && (winSel == WIN_CMN);
  assign devSel    = hostValid && (winSel == WIN_DEV);
  assign tblSel    = hostValid && (winSel == WIN_TBL);
  assign pbaSel    = hostValid && (winSel == WIN_PBA);
  assign subWrite  = hostValid && hostWrite;
  assign subOffset = offSel;
  assign bellIdx   = offSel[QIDX_W+1:2];

  // R10: one target at most per access
  a_r10_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmnSel, devSel, tblSel, pbaSel, strb.causeRd, strb.causeWr, strb.bellWr}));

  // R10: nothing selected without a request
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !hostValid |-> !(cmnSel || devSel || tblSel || pbaSel));

  // R9: offsets past the region end reach nothing
  a_r9_outside_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && (addrExt >= REGION_BYTES)) |->
      !(cmnSel || devSel || tblSel || pbaSel || strb.causeRd || strb.causeWr || strb.bellWr));

endmodule

// File: rtl/vdev_bar_datapath.sv
module vdev_bar_datapath
  import vdev_bar_pkg::*;
#(
  parameter int QIDX_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strbT              strb,
  input  logic              laneZeroEn,
  input  logic [7:0]        clrData,
  input  logic [QIDX_W-1:0] bellIdx,
  input  logic              raiseUsed,
  input  logic              raiseCfg,
  input  logic [31:0]       cmnRdata,
  input  logic [31:0]       devRdata,
  input  logic [31:0]       tblRdata,
  input  logic [31:0]       pbaRdata,
  output logic              hostRvalid,
  output logic [31:0]       hostRdata,
  output logic              notifyValid,
  output logic [QIDX_W-1:0] notifyQueue
);

  logic [7:0]  causeReg;
  logic [7:0]  causeNext;
  logic [7:0]  clrMask;
  logic [7:0]  raiseVec;
  logic [31:0] rdMux;

  always_comb begin
    raiseVec = '0;
    raiseVec[CAUSE_USED_BIT] = raiseUsed;
    raiseVec[CAUSE_CFG_BIT]  = raiseCfg;
  end

  always_comb begin
    clrMask = '0;
    if (strb.causeRd && laneZeroEn) clrMask = 8'hFF;
    else if (strb.causeWr && laneZeroEn) clrMask = clrData;
  end

  // raise applied after the clear so a same-cycle cause survives
  assign causeNext = (causeReg & ~clrMask) | raiseVec;

  always_comb begin
    case (strb.rdSrc)
      WIN_CMN:   rdMux = cmnRdata;
      WIN_DEV:   rdMux = devRdata;
      WIN_TBL:   rdMux = tblRdata;
      WIN_PBA:   rdMux = pbaRdata;
      WIN_CAUSE: rdMux = {24'h0, laneZeroEn ? causeReg : 8'h00};
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeReg    <= '0;
      hostRvalid  <= 1'b0;
      hostRdata   <= '0;
      notifyValid <= 1'b0;
      notifyQueue <= '0;
    end else begin
      causeReg    <= causeNext;
      hostRvalid  <= strb.rdStrobe;
      hostRdata   <= strb.rdStrobe ? rdMux : '0;
      notifyValid <= strb.bellWr;
      if (strb.bellWr) notifyQueue <= bellIdx;
    end
  end

  // R7: a raised cause is visible next cycle regardless of clears
  a_r7_used_kept: assert property (@(posedge clk) disable iff (!rstN)
    raiseUsed |=> causeReg[CAUSE_USED_BIT]);
  a_r7_cfg_kept: assert property (@(posedge clk) disable iff (!rstN)
    raiseCfg |=> causeReg[CAUSE_CFG_BIT]);

  // R5: read-to-clear with no raise empties the byte
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.causeRd && laneZeroEn && !raiseUsed && !raiseCfg) |=> (causeReg == 8'h00));

endmodule

// File: rtl/vdev_bar_decoder.sv
module vdev_bar_decoder
  import vdev_bar_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SUB_OFF_W = 18,
  parameter int QIDX_W    = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostValid,
  input  logic                 hostWrite,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [3:0]           hostByteEn,
  input  logic [31:0]          hostWdata,
  output logic                 hostRvalid,
  output logic [31:0]          hostRdata,
  input  logic                 raiseUsed,
  input  logic                 raiseCfg,
  output logic                 subWrite,
  output logic [SUB_OFF_W-1:0] subOffset,
  output logic [3:0]           subByteEn,
  output logic [31:0]          subWdata,
  output logic                 cmnSel,
  input  logic [31:0]          cmnRdata,
  output logic                 devSel,
  input  logic [31:0]          devRdata,
  output logic                 tblSel,
  input  logic [31:0]          tblRdata,
  output logic                 pbaSel,
  input  logic [31:0]          pbaRdata,
  output logic                 notifyValid,
  output logic [QIDX_W-1:0]    notifyQueue
);

  strbT              strb;
  logic [QIDX_W-1:0] bellIdx;

  vdev_bar_ctrl #(
    .ADDR_W(ADDR_W), .SUB_OFF_W(SUB_OFF_W), .QIDX_W(QIDX_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .hostValid(hostValid), .hostWrite(hostWrite), .hostAddr(hostAddr),
    .strb(strb), .subWrite(subWrite), .subOffset(subOffset),
    .cmnSel(cmnSel), .devSel(devSel), .tblSel(tblSel), .pbaSel(pbaSel),
    .bellIdx(bellIdx)
  );

  vdev_bar_datapath #(.QIDX_W(QIDX_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .laneZeroEn(hostByteEn[0]), .clrData(hostWdata[7:0]), .bellIdx(bellIdx),
    .raiseUsed(raiseUsed), .raiseCfg(raiseCfg),
    .cmnRdata(cmnRdata), .devRdata(devRdata), .tblRdata(tblRdata), .pbaRdata(pbaRdata),
    .hostRvalid(hostRvalid), .hostRdata(hostRdata),
    .notifyValid(notifyValid), .notifyQueue(notifyQueue)
  );

  assign subByteEn = hostByteEn;
  assign subWdata  = hostWdata;

  // R2: every response answers a read in the previous cycle
  a_r2_resp_from_read: assert property (@(posedge clk) disable iff (!rstN)
    hostRvalid |-> $past(hostValid && !hostWrite));

  // R8: every doorbell pulse answers a write in the previous cycle
  a_r8_bell_from_write: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid |-> $past(hostValid && hostWrite));

endmodule

// File: tb/vdev_bar_decoder_test.sv
`timescale 1ns/1ps
module vdev_bar_decoder_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid = 1'b0, hostWrite = 1'b0;
  logic [19:0] hostAddr = '0;
  logic [3:0]  hostByteEn = '0;
  logic [31:0] hostWdata = '0;
  logic        hostRvalid;
  logic [31:0] hostRdata;
  logic        raiseUsed = 1'b0, raiseCfg = 1'b0;
  logic        subWrite;
  logic [17:0] subOffset;
  logic [3:0]  subByteEn;
  logic [31:0] subWdata;
  logic        cmnSel, devSel, tblSel, pbaSel;
  logic [31:0] cmnRdata, devRdata, tblRdata, pbaRdata;
  logic        notifyValid;
  logic [9:0]  notifyQueue;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vdev_bar_decoder uut (
    .clk(clk), .rstN(rstN),
    .hostValid(hostValid), .hostWrite(hostWrite), .hostAddr(hostAddr),
    .hostByteEn(hostByteEn), .hostWdata(hostWdata),
    .hostRvalid(hostRvalid), .hostRdata(hostRdata),
    .raiseUsed(raiseUsed), .raiseCfg(raiseCfg),
    .subWrite(subWrite), .subOffset(subOffset), .subByteEn(subByteEn), .subWdata(subWdata),
    .cmnSel(cmnSel), .cmnRdata(cmnRdata), .devSel(devSel), .devRdata(devRdata),
    .tblSel(tblSel), .tblRdata(tblRdata), .pbaSel(pbaSel), .pbaRdata(pbaRdata),
    .notifyValid(notifyValid), .notifyQueue(notifyQueue)
  );

  // sub-port stand-ins: plain word memories indexed by the relative offset
  logic [31:0] cmnMem [16];
  logic [31:0] devMem [1024];
  logic [31:0] tblMem [4096];
  logic [31:0] pbaMem [512];

  assign cmnRdata = cmnMem[subOffset[5:2]];
  assign devRdata = devMem[subOffset[11:2]];
  assign tblRdata = tblMem[subOffset[13:2]];
  assign pbaRdata = pbaMem[subOffset[10:2]];

  function automatic logic [31:0] mergeBytes(input logic [31:0] oldW, input logic [31:0] newW,
                                             input logic [3:0] be);
    logic [31:0] r;
    r = oldW;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = newW[8*b +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) cmnMem[i] <= '0;
      for (int i = 0; i < 1024; i++) devMem[i] <= '0;
      for (int i = 0; i < 4096; i++) tblMem[i] <= '0;
      for (int i = 0; i < 512; i++) pbaMem[i] <= '0;
    end else if (subWrite) begin
      if (cmnSel) cmnMem[subOffset[5:2]]  <= mergeBytes(cmnRdata, subWdata, subByteEn);
      if (devSel) devMem[subOffset[11:2]] <= mergeBytes(devRdata, subWdata, subByteEn);
      if (tblSel) tblMem[subOffset[13:2]] <= mergeBytes(tblRdata, subWdata, subByteEn);
      if (pbaSel) pbaMem[subOffset[10:2]] <= mergeBytes(pbaRdata, subWdata, subByteEn);
    end
  end

  // behavioural model of the whole region
  logic [31:0] modelMem [int];
  logic [7:0]  modelCause = 8'h00;

  // 0 gap, 1 common, 2 cause, 3 device, 4 doorbell, 5 table, 6 pending
  function automatic int regionOf(input logic [19:0] a);
    int x;
    x = int'(a);
    if (x < 56) return 1;
    if (x >= 'h2000 && x < 'h2004) return 2;
    if (x >= 'h4000 && x < 'h5000) return 3;
    if (x >= 'h6000 && x < 'h7000) return 4;
    if (x >= 'h8000 && x < 'h48000) return 5;
    if (x >= 'h48000 && x < 'h48800) return 6;
    return 0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one bus cycle; entered and left at a falling edge
  task automatic access(input logic v, input logic wr, input logic [19:0] a,
                        input logic [3:0] be, input logic [31:0] d,
                        input logic ru, input logic rc, input string tag);
    int r;
    int key;
    logic [3:0]  expSel;
    logic        expRv, expNv;
    logic [31:0] expRd;
    logic [9:0]  expQ;
    logic [7:0]  clr;
    hostValid = v; hostWrite = wr; hostAddr = a; hostByteEn = be; hostWdata = d;
    raiseUsed = ru; raiseCfg = rc;
    r = v ? regionOf(a) : -1;
    key = int'(a) >> 2;
    expSel = {r == 1, r == 3, r == 5, r == 6};
    #1;
    chk("R10", "selects", {28'h0, cmnSel, devSel, tblSel, pbaSel}, {28'h0, expSel});
    expRv = v && !wr;
    expRd = '0;
    expNv = v && wr && (r == 4);
    expQ  = a[11:2];
    clr   = '0;
    if (expRv) begin
      if (r == 1 || r == 3 || r == 5 || r == 6)
        expRd = modelMem.exists(key) ? modelMem[key] : 32'h0;
      else if (r == 2)
        expRd = be[0] ? {24'h0, modelCause} : 32'h0;
    end
    if (v && r == 2 && be[0]) clr = wr ? d[7:0] : 8'hFF;
    if (v && wr && (r == 1 || r == 3 || r == 5 || r == 6))
      modelMem[key] = mergeBytes(modelMem.exists(key) ? modelMem[key] : 32'h0, d, be);
    modelCause = (modelCause & ~clr) | {6'h0, rc, ru};
    @(posedge clk);
    @(negedge clk);
    hostValid = 1'b0; hostWrite = 1'b0; raiseUsed = 1'b0; raiseCfg = 1'b0;
    chk("R2", "rvalid", {31'h0, hostRvalid}, {31'h0, expRv});
    if (expRv) chk(tag, "rdata", hostRdata, expRd);
    chk("R8", "notifyValid", {31'h0, notifyValid}, {31'h0, expNv});
    if (expNv) chk("R8", "notifyQueue", {22'h0, notifyQueue}, {22'h0, expQ});
  endtask

  task automatic rd(input logic [19:0] a, input logic [3:0] be, input string tag);
    access(1'b1, 1'b0, a, be, 32'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic wr(input logic [19:0] a, input logic [3:0] be, input logic [31:0] d,
                    input string tag);
    access(1'b1, 1'b1, a, be, d, 1'b0, 1'b0, tag);
  endtask

  task automatic idle(input logic ru, input logic rc);
    access(1'b0, 1'b0, 20'h0, 4'h0, 32'h0, ru, rc, "R7");
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL R2 watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "rvalid in reset", {31'h0, hostRvalid}, 32'h0);
    chk("R1", "notify in reset", {31'h0, notifyValid}, 32'h0);
    rstN = 1'b1;
    rd(20'h02000, 4'hF, "R1");

    // R3: queue-setup window, first and last dword, then the gap after it
    wr(20'h00000, 4'hF, 32'h1111_2222, "R3");
    wr(20'h00034, 4'hF, 32'hA5A5_0034, "R3");
    wr(20'h00038, 4'hF, 32'hDEAD_0038, "R9");
    rd(20'h00000, 4'hF, "R3");
    rd(20'h00034, 4'hF, "R3");
    rd(20'h00038, 4'hF, "R9");

    // R4: device, table and pending windows with relative offsets
    wr(20'h04000, 4'hF, 32'h0D00_0001, "R4");
    wr(20'h04FFC, 4'hF, 32'hFFFF_FFFF, "R4");
    wr(20'h04FFC, 4'b0101, 32'h1234_5678, "R4");
    wr(20'h08000, 4'hF, 32'h7AB0_0000, "R4");
    wr(20'h47FFC, 4'hF, 32'h7AB3_FFFC, "R4");
    wr(20'h48000, 4'hF, 32'h0BA0_0000, "R4");
    wr(20'h487FC, 4'hF, 32'h0BA0_07FC, "R4");
    rd(20'h04000, 4'hF, "R4");
    rd(20'h04FFC, 4'hF, "R4");
    rd(20'h08000, 4'hF, "R4");
    rd(20'h47FFC, 4'hF, "R4");
    rd(20'h48000, 4'hF, "R4");
    rd(20'h487FC, 4'hF, "R4");

    // R9: gaps and beyond the region, then prove nothing moved
    wr(20'h02004, 4'hF, 32'hBAD0_0001, "R9");
    wr(20'h05000, 4'hF, 32'hBAD0_0002, "R9");
    wr(20'h07000, 4'hF, 32'hBAD0_0003, "R9");
    wr(20'h48800, 4'hF, 32'hBAD0_0004, "R9");
    wr(20'h80000, 4'hF, 32'hBAD0_0005, "R9");
    wr(20'hC4000, 4'hF, 32'hBAD0_0006, "R9");
    rd(20'h05000, 4'hF, "R9");
    rd(20'h48800, 4'hF, "R9");
    rd(20'h80000, 4'hF, "R9");
    rd(20'hC4000, 4'hF, "R9");
    rd(20'h04000, 4'hF, "R9");
    rd(20'h00000, 4'hF, "R9");
    rd(20'h04000 + 20'h04000 - 20'h04000, 4'hF, "R9");

    // R5 / R7: raise, read-to-clear, read again
    idle(1'b1, 1'b0);
    rd(20'h02000, 4'hF, "R5");
    rd(20'h02000, 4'hF, "R5");
    // R5: byte-enable 0 clear gives zero and keeps the byte
    idle(1'b0, 1'b1);
    rd(20'h02000, 4'b1110, "R5");
    rd(20'h02000, 4'h1, "R5");

    // R6: write clears only the ones in the data
    idle(1'b1, 1'b1);
    wr(20'h02000, 4'hF, 32'hFFFF_FF01, "R6");
    rd(20'h02000, 4'hF, "R6");
    idle(1'b1, 1'b1);
    wr(20'h02000, 4'b1110, 32'h0000_00FF, "R6");
    rd(20'h02000, 4'hF, "R6");

    // R7: raise in the same cycle as the clearing read / write
    idle(1'b1, 1'b0);
    access(1'b1, 1'b0, 20'h02000, 4'hF, 32'h0, 1'b0, 1'b1, "R7");
    rd(20'h02000, 4'hF, "R7");
    idle(1'b1, 1'b1);
    access(1'b1, 1'b1, 20'h02000, 4'hF, 32'h0000_0003, 1'b1, 1'b0, "R7");
    rd(20'h02000, 4'hF, "R7");

    // R8: doorbell writes at both ends and in the middle, then a read
    wr(20'h06000, 4'hF, 32'h0, "R8");
    wr(20'h06014, 4'h1, 32'h0, "R8");
    wr(20'h06FFC, 4'hF, 32'hFFFF_FFFF, "R8");
    rd(20'h06008, 4'hF, "R8");
    idle(1'b0, 1'b0);

    // R2: back-to-back reads across windows
    rd(20'h00034, 4'hF, "R2");
    rd(20'h487FC, 4'hF, "R2");
    rd(20'h02000, 4'hF, "R2");
    rd(20'h47FFC, 4'hF, "R2");
    idle(1'b0, 1'b0);

    finishRun();
  end

endmodule